// File: doc/BRIEF.md
# Interrupt-Capable Parallel Pin Controller

This block manages a bank of 32 general-purpose pins through a flat 32-bit register bus with a combinational read path. For each pin, software chooses whether it is an input or an output, whether an output acts as open-drain, and what level it should drive. The block does not contain pad drivers. It presents an output-enable vector and an output-level vector to the pad ring, and it receives the raw pad levels back.

Pad levels pass through a multi-flop synchroniser. The block then compares each synchronised level with its value one cycle earlier. A transition on an input pin that matches that pin's sense setting sets a sticky event bit. Software clears an event bit by writing a one to it. A single interrupt line is raised whenever a pending event has its enable bit set.

A build-time parameter picks the sense scheme. In the single-bit scheme, each pin has one control bit that selects falling edges only or both edges. In the two-bit scheme, each pin has a two-bit field: the first control register holds the fields for pins 0 to 15 and the second holds those for pins 16 to 31. Each field selects rising, falling, both edges or none.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, every register reads zero. No pin is driven and the interrupt output is low.
- R2: Pin n occupies bit 31−n of every per-pin register, so pin 0 is bit 31. Byte offsets are: direction 0x00, open-drain 0x04, level 0x08, event 0x0C, enable 0x10, control A 0x14, control B 0x18.
- R3: A direction bit of 1 makes the pin an output, and pad_oe is never set for an input pin. pad_out always equals the stored level register.
- R4: An output pin whose open-drain bit is 1 is driven only while its stored level is 0.
- R5: Reading offset 0x08 returns the synchronised pad level for input pins and the stored level for output pins.
- R6: A pad change enters an event bit on the third rising clock edge after it appears (two synchroniser stages, then the event register). The event is not yet visible after the second edge.
- R7: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. A qualifying edge in the same cycle as its clear leaves the bit set. Events stay set until they are cleared.
- R8: irq_out is high exactly when the event register ANDed with the enable register is nonzero. An enable bit of 1 admits that pin.
- R9: In the single-bit scheme, control A bit 31−n = 1 latches only falling edges on pin n, and 0 latches both edges.
- R10: In the two-bit scheme, pins 0–15 use control A and pins 16–31 use control B. Pin n's field sits at bits [(15−(n mod 16))·2 +: 2]. The value 01 selects rising, 10 selects falling and 00 selects both edges.
- R11: In the two-bit scheme, a field value of 11 latches no events on that pin.
- R12: Pins configured as outputs latch no events.
- R13: In the single-bit scheme, control B ignores writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Combinational read data |
| pad_in | input | NPINS | Raw pad levels (asynchronous) |
| pad_oe | output | NPINS | Per-pin drive enable toward the pads |
| pad_out | output | NPINS | Per-pin level toward the pads |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a qualifying edge that arrives in the same cycle as a software clear of that same event bit. The only route to it is through the synchroniser latency. The stimulus changes the pad level on a falling clock edge, waits exactly two more falling edges, and then presents the clear write, so that both land on the third rising edge. The same latency is checked directly: the event must still be absent one edge before it lands. Two instances, one per sense scheme, receive identical stimulus, so that each control setting is judged under both encodings.

// File: rtl/pin_bank_pkg.sv
`timescale 1ns/1ps
package pin_bank_pkg;
   // register byte offsets
   localparam int unsigned REG_DIR = 'h00;
   localparam int unsigned REG_ODE = 'h04;
   localparam int unsigned REG_LVL = 'h08;
   localparam int unsigned REG_EVT = 'h0C;
   localparam int unsigned REG_ENA = 'h10;
   localparam int unsigned REG_CTA = 'h14;
   localparam int unsigned REG_CTB = 'h18;

   // two-bit sense field encoding
   typedef enum logic [1:0] {
      SNS_BOTH = 2'b00,
      SNS_RISE = 2'b01,
      SNS_FALL = 2'b10,
      SNS_NONE = 2'b11
   } sense_e;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pin_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               if (s == 0) stage_q[s] <= d;
               else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_edge_sense.sv
`timescale 1ns/1ps
module pin_edge_sense
   import pin_bank_pkg::*;
#(
   parameter int NPINS      = 32,
   parameter int SENSE_BITS = 2
) (
   input  logic [NPINS-1:0] cur,
   input  logic [NPINS-1:0] prev,
   input  logic [NPINS-1:0] arm,
   input  logic [NPINS-1:0] ctl_a,
   input  logic [NPINS-1:0] ctl_b,
   output logic [NPINS-1:0] hit
);
   localparam int HALF = NPINS / 2;

   logic [NPINS-1:0] rise, fall;
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   generate
      if (SENSE_BITS == 1) begin : g_one_bit
         logic [NPINS-1:0] unused_ctl_b;
         assign unused_ctl_b = ctl_b;
         for (genvar b = 0; b < NPINS; b++) begin : g_bit
            assign hit[b] = arm[b] & (fall[b] | (rise[b] & ~ctl_a[b]));
         end
      end else begin : g_two_bit
         for (genvar b = 0; b < NPINS; b++) begin : g_bit
            localparam int PIN = NPINS - 1 - b;
            localparam int POS = (HALF - 1 - (PIN % HALF)) * 2;
            sense_e sel;
            if (PIN < HALF) begin : g_lo
               assign sel = sense_e'(ctl_a[POS +: 2]);
            end else begin : g_hi
               assign sel = sense_e'(ctl_b[POS +: 2]);
            end
            assign hit[b] = arm[b] & (((sel == SNS_RISE) & rise[b]) |
                                      ((sel == SNS_FALL) & fall[b]) |
                                      ((sel == SNS_BOTH) & (rise[b] | fall[b])));
         end
      end
   endgenerate
endmodule

// File: rtl/pin_event_store.sv
`timescale 1ns/1ps
module pin_event_store #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic [W-1:0] clr,
   output logic [W-1:0] evt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~clr) | hit;   // new edge wins over clear
   end
endmodule

// File: rtl/pin_bank_ctrl.sv
`timescale 1ns/1ps
module pin_bank_ctrl
   import pin_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int AW          = 8,
   parameter int SENSE_BITS  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_out,
   output logic             irq_out
);
   generate
      if (NPINS != 32) begin : g_bad_pins
         $error("pin_bank_ctrl register layout assumes 32 pins");
      end
      if (SENSE_BITS != 1 && SENSE_BITS != 2) begin : g_bad_sense
         $error("SENSE_BITS must be 1 or 2");
      end
      if (AW < 5) begin : g_bad_aw
         $error("AW too narrow for the register map");
      end
   endgenerate

   logic [NPINS-1:0] dir_q, ode_q, lvl_q, ena_q, cta_q, ctb_q;
   logic [NPINS-1:0] sync_lvl, prev_q, hit, clr, evt_q;

   function automatic logic sel(input logic [AW-1:0] a, input int unsigned off);
      return a == AW'(off);
   endfunction

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         ode_q <= '0;
         lvl_q <= '0;
         ena_q <= '0;
         cta_q <= '0;
      end else if (bus_we) begin
         if (sel(bus_addr, REG_DIR)) dir_q <= bus_wdata;
         if (sel(bus_addr, REG_ODE)) ode_q <= bus_wdata;
         if (sel(bus_addr, REG_LVL)) lvl_q <= bus_wdata;
         if (sel(bus_addr, REG_ENA)) ena_q <= bus_wdata;
         if (sel(bus_addr, REG_CTA)) cta_q <= bus_wdata;
      end
   end

   generate
      if (SENSE_BITS == 2) begin : g_ctb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                ctb_q <= '0;
            else if (bus_we && sel(bus_addr, REG_CTB)) ctb_q <= bus_wdata;
         end
      end else begin : g_no_ctb
         assign ctb_q = '0;
      end
   endgenerate

   // input path
   pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_lvl;
   end

   pin_edge_sense #(.NPINS(NPINS), .SENSE_BITS(SENSE_BITS)) i_sense (
      .cur   (sync_lvl),
      .prev  (prev_q),
      .arm   (~dir_q),
      .ctl_a (cta_q),
      .ctl_b (ctb_q),
      .hit   (hit)
   );

   assign clr = (bus_we && sel(bus_addr, REG_EVT)) ? bus_wdata : '0;

   pin_event_store #(.W(NPINS)) i_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .clr   (clr),
      .evt_q (evt_q)
   );

   // read path
   always_comb begin
      bus_rdata = '0;
      if (sel(bus_addr, REG_DIR)) bus_rdata = dir_q;
      if (sel(bus_addr, REG_ODE)) bus_rdata = ode_q;
      if (sel(bus_addr, REG_LVL)) bus_rdata = (sync_lvl & ~dir_q) | (lvl_q & dir_q);
      if (sel(bus_addr, REG_EVT)) bus_rdata = evt_q;
      if (sel(bus_addr, REG_ENA)) bus_rdata = ena_q;
      if (sel(bus_addr, REG_CTA)) bus_rdata = cta_q;
      if (sel(bus_addr, REG_CTB)) bus_rdata = ctb_q;
   end

   // pad side
   assign pad_oe  = dir_q & ~(ode_q & lvl_q);
   assign pad_out = lvl_q;
   assign irq_out = |(evt_q & ena_q);
endmodule

// File: rtl/pin_bank_ctrl_chk.sv
`timescale 1ns/1ps
module pin_bank_ctrl_chk
   import pin_bank_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    bus_addr,
   input logic             bus_we,
   input logic [NPINS-1:0] bus_wdata,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] pad_out,
   input logic             irq_out,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] ode_q,
   input logic [NPINS-1:0] evt_q
);
   logic [NPINS-1:0] wr_clear;
   assign wr_clear = (bus_we && bus_addr == AW'(REG_EVT)) ? bus_wdata : '0;

   // R7: a pending event survives unless a one was written to it
   p_evt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_q) & ~$past(wr_clear) & ~evt_q) == '0));

   // R12: no event appears on a pin that was an output
   p_out_no_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_q & ~$past(evt_q) & $past(dir_q)) == '0));

   // R3: clearing all direction bits stops all driving
   p_dir_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(REG_DIR) && bus_wdata == '0) |=> (pad_oe == '0));

   // R3: inputs are never driven
   p_in_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_q) == '0));

   // R4: an open-drain pin only ever drives low
   p_od_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ode_q & pad_out) == '0));

   // R8: disabling every pin drops the interrupt
   p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(REG_ENA) && bus_wdata == '0) |=> !irq_out);
endmodule

bind pin_bank_ctrl pin_bank_ctrl_chk #(.NPINS(NPINS), .AW(AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .irq_out   (irq_out),
   .dir_q     (dir_q),
   .ode_q     (ode_q),
   .evt_q     (evt_q)
);

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;
   import pin_bank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic        we;
   logic [31:0] wdata, pad;
   logic [31:0] rd_a, oe_a, out_a, rd_b, oe_b, out_b;
   logic        irq_a, irq_b;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   // two-bit sense scheme
   pin_bank_ctrl #(.SENSE_BITS(2)) i_pin_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_a), .pad_in(pad), .pad_oe(oe_a), .pad_out(out_a), .irq_out(irq_a));

   // single-bit sense scheme, same stimulus
   pin_bank_ctrl #(.SENSE_BITS(1)) i_pin_bank_ctrl_one (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rd_b), .pad_in(pad), .pad_oe(oe_b), .pad_out(out_b), .irq_out(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned off, input logic [31:0] v);
      @(negedge clk);
      we = 1'b1; addr = 8'(off); wdata = v;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic look(input int unsigned off);
      @(negedge clk);
      addr = 8'(off);
      #1;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int o = 0; o <= 24; o += 4) begin
         look(o);
         chk("R1 register a", rd_a, 32'h0);
         chk("R1 register b", rd_b, 32'h0);
      end
      chk("R1 pad_oe", oe_a, 32'h0);
      chk("R1 irq", {31'h0, irq_a}, 32'h0);
   endtask

   task automatic t_dir_level();
      wr(REG_DIR, 32'h8000_0020);            // pins 0 and 26 output (R2)
      wr(REG_LVL, 32'hFFFF_FFFF);
      @(negedge clk) pad = 32'h0F0F_0F0F;
      settle();
      #1;
      chk("R3 pad_oe from direction", oe_a, 32'h8000_0020);
      chk("R3 pad_out from level", out_a, 32'hFFFF_FFFF);
      look(REG_LVL);
      chk("R5 level read mix", rd_a, 32'h8F0F_0F2F);
   endtask

   task automatic t_open_drain();
      wr(REG_ODE, 32'h0000_0020);
      #1 chk("R4 open-drain high released", oe_a, 32'h8000_0000);
      wr(REG_LVL, 32'h0);
      #1 chk("R4 open-drain low driven", oe_a, 32'h8000_0020);
      chk("R3 pad_out follows level", out_a, 32'h0);
   endtask

   task automatic t_output_no_event();
      wr(REG_EVT, 32'hFFFF_FFFF);
      @(negedge clk) pad = 32'h8F0F_0F0F;   // only output pin 0 moves
      settle();
      look(REG_EVT);
      chk("R12 output pin latched nothing", rd_a, 32'h0);
      wr(REG_DIR, 32'h0);
      wr(REG_ODE, 32'h0);
      @(negedge clk) pad = 32'h0;
      settle();
      wr(REG_EVT, 32'hFFFF_FFFF);
      look(REG_EVT);
      chk("R7 write-all-ones clears", rd_a, 32'h0);
   endtask

   task automatic t_sense();
      wr(REG_CTA, 32'h6300_0000);   // pin0 rise, pin1 fall, pin2 both, pin3 none
      wr(REG_CTB, 32'h4000_0002);   // pin16 rise, pin31 fall
      @(negedge clk);
      pad = 32'hF000_8001; addr = 8'(REG_EVT);
      repeat (2) @(negedge clk);
      #1 chk("R6 not yet after two edges", rd_a, 32'h0);
      @(negedge clk);
      #1 chk("R10 R11 rising two-bit", rd_a, 32'hA000_8000);
      chk("R9 rising one-bit", rd_b, 32'h9000_8001);
      wr(REG_EVT, 32'hFFFF_FFFF);
      @(negedge clk) pad = 32'h0;
      settle();
      look(REG_EVT);
      chk("R10 R11 falling two-bit", rd_a, 32'h6000_0001);
      chk("R9 falling one-bit", rd_b, 32'hF000_8001);
      look(REG_CTB);
      chk("R10 control B held", rd_a, 32'h4000_0002);
      chk("R13 control B absent in one-bit", rd_b, 32'h0);
   endtask

   task automatic t_irq();
      #1 chk("R8 irq masked", {30'h0, irq_a, irq_b}, 32'h0);
      wr(REG_ENA, 32'h0000_0001);
      #1 chk("R8 irq pin31 enabled", {30'h0, irq_a, irq_b}, 32'h3);
      wr(REG_ENA, 32'h0000_8000);
      #1 chk("R8 irq only where pending", {30'h0, irq_a, irq_b}, 32'h1);
   endtask

   task automatic t_clear();
      wr(REG_EVT, 32'h0);
      look(REG_EVT);
      chk("R7 zero write keeps events", rd_a, 32'h6000_0001);
      wr(REG_EVT, 32'h0000_0001);
      look(REG_EVT);
      chk("R7 one write clears bit", rd_a, 32'h6000_0000);
   endtask

   task automatic t_collision();
      @(negedge clk) pad = 32'h2000_0000;   // pin2 rises
      @(negedge clk);
      @(negedge clk);
      we = 1'b1; addr = 8'(REG_EVT); wdata = 32'h2000_0000;
      @(negedge clk) we = 1'b0;
      look(REG_EVT);
      chk("R7 edge beats clear", rd_a, 32'h6000_0000);
      chk("R7 clear without edge", rd_b, 32'hD000_8000);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_dir_level();
      t_open_drain();
      t_output_no_event();
      t_sense();
      t_irq();
      t_clear();
      t_collision();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule